// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Port

This block places a 128-word, 16-bit-per-word serial EEPROM behind one byte-wide register that software reaches through a memory window. Software toggles chip select, serial clock and serial data-in by writing that register and samples the serial data-out by reading it back. A bit-level state machine inside the block follows each write. It spots rising and falling edges on the clock and chip-select bits, takes a start bit, collects a command and address, then runs one of seven operations: read, single-word write, single-word erase, write-all, erase-all, write-enable and write-disable. The words are kept in an internal register array.

A two-step unlock guards the register. Software first writes a key to bus region 0 and then a second key to bus region 2. Until both steps have landed, the register reads as all ones and ignores writes. All bus writes are registered, so each write takes effect at the next clock edge. The read data path is combinational from the stored register.

Top module: `serial_eeprom_port`

## Requirements
- R1: A write of 0x0A to bus region 0 sets unlock bit A. A write of any other value to region 0 clears both unlock bits A and B.
- R2: A write of 0x40 to bus region 2 sets unlock bit B. Any other value written there clears bit B and leaves bit A unchanged. `gate_open` is high exactly when both bits are set.
- R3: While the gate is closed, a read at the serial register returns 0xFF, and writes to the serial register leave its contents unchanged.
- R4: The serial register sits at region 5, offset 0x80. Its bit 7 is chip select, bit 6 is serial clock, bit 1 is data-in and bit 0 is data-out. A read at any other offset returns 0xFF, and a write to any other offset has no effect.
- R5: A rising edge on chip select returns the state machine to idle and drops any command that was only partly shifted in.
- R6: In idle, a rising clock with data-in at 1 is the start bit. The next 10 rising clocks shift in a command MSB first. Bits 9:8 are the opcode (01 write, 10 read, 11 erase, 00 extended). Bits 7:6 are the extended sub-code (11 enable, 00 disable, 01 write-all, 10 erase-all). Bits 6:0 are the word address.
- R7: A write command shifts in 16 data bits MSB first. On the 16th bit it stores the word only if writes are enabled, and then it returns to idle.
- R8: A read command drives data-out to 0 on the 10th command clock as a dummy bit. Each of the next 16 rising clocks then puts out one bit of the word, MSB first. After the 16th bit the state machine returns to idle.
- R9: When writes are enabled, erase sets the addressed word to 0xFFFF and erase-all sets every word to 0xFFFF. When writes are disabled, both leave the storage unchanged.
- R10: Write-all shifts in 16 data bits and, when writes are enabled, stores that value in all 128 words.
- R11: The enable command allows later write, erase, write-all and erase-all commands to change the storage. The disable command blocks them.
- R12: Data-out reads 1 after any register write that does not drive it. A write that makes the clock fall while chip select stays high keeps the previous data-out value.
- R13: After reset, every word holds 0xFFFF, writes are disabled, the gate is closed and the serial register holds 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_region | input | 3 | Bus region of the write (address bits 15:13) |
| wr_offset | input | 8 | Low byte of the write address within the region |
| wr_data | input | 8 | Bus write data |
| rd_offset | input | 8 | Low byte of the read address within the memory window |
| rd_data | output | 8 | Read data for the addressed offset |
| gate_open | output | 1 | High when both unlock steps have been written |

## Verification
The bench runs a write, a read and an erase with writes still disabled after reset. A design that stored data regardless of the enable flag would return the written word instead of 0xFFFF. During every read it checks the dummy zero and then holds the clock low between rising edges. A design that put out the MSB one edge early, or that let data-out float high on a falling clock, would show up bit by bit. It also abandons a half-sent command, raises chip select again and runs a clean read. A design that ignored the chip-select edge would mix the stale bits into the new command. Finally, it uses the partial gate sequences: key B alone, a wrong key in region 0 after opening, and a wrong key in region 2. A design that cleared the wrong unlock bit, or only one of them, would open or stay open when it should not.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

    // Bit positions inside the software-visible serial register
    localparam int PIN_CS  = 7;
    localparam int PIN_CLK = 6;
    localparam int PIN_DI  = 1;
    localparam int PIN_DO  = 0;

    // Command opcodes (bits 9:8 of the shifted command)
    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // Extended sub-codes (bits 7:6 when the opcode is OPC_EXT)
    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_WIPE   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_CMD,
        SER_SHOUT,
        SER_DATA_ONE,
        SER_DATA_ALL
    } ser_state_e;

endpackage

// File: rtl/serial_eeprom_gate.sv
module serial_eeprom_gate #(
    parameter logic [2:0] REGION_A = 3'd0,
    parameter logic [2:0] REGION_B = 3'd2,
    parameter logic [7:0] KEY_A    = 8'h0A,
    parameter logic [7:0] KEY_B    = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_region,
    input  logic [7:0] wr_data,
    output logic       open_o
);

    typedef struct packed {
        logic step_a;
        logic step_b;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (wr_en && wr_region == REGION_A) begin
            if (wr_data == KEY_A) begin
                gate_d.step_a = 1'b1;
            end else begin
                gate_d.step_a = 1'b0;
                gate_d.step_b = 1'b0;
            end
        end else if (wr_en && wr_region == REGION_B) begin
            gate_d.step_b = (wr_data == KEY_B);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign open_o = gate_q.step_a && gate_q.step_b;

endmodule

// File: rtl/serial_eeprom_store.sv
module serial_eeprom_store #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] word_q [WORDS];

    generate
        for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
            logic hit;
            assign hit = we_all || (we_one && waddr == ADDR_W'(gi));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q[gi] <= '1;
                end else if (hit) begin
                    word_q[gi] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = word_q[raddr];

endmodule

// File: rtl/serial_eeprom_fsm.sv
module serial_eeprom_fsm
    import serial_eeprom_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int DATA_W = 16,
    localparam int ADDR_W   = $clog2(WORDS),
    localparam int CMD_BITS = ADDR_W + 3,
    localparam int CNT_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_q,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we_one,
    output logic              mem_we_all,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        ser_state_e        st;
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              wen;
        logic [7:0]        pins;
    } ser_t;

    ser_t s_d, s_q;

    logic [DATA_W-1:0] shifted;
    logic [CNT_W-1:0]  cnt_inc;
    logic [1:0]        opc;
    logic [1:0]        sub;
    logic [7:0]        pins_new;
    logic              cs_rise, clk_rise, clk_fall;

    assign shifted  = {s_q.sr[DATA_W-2:0], reg_wdata[PIN_DI]};
    assign cnt_inc  = s_q.cnt + CNT_W'(1);
    assign opc      = shifted[CMD_BITS-1 -: 2];
    assign sub      = shifted[CMD_BITS-3 -: 2];
    assign cs_rise  = !s_q.pins[PIN_CS]  &&  reg_wdata[PIN_CS];
    assign clk_rise = !s_q.pins[PIN_CLK] &&  reg_wdata[PIN_CLK];
    assign clk_fall =  s_q.pins[PIN_CLK] && !reg_wdata[PIN_CLK];
    assign mem_raddr = shifted[ADDR_W-1:0];

    always_comb begin
        s_d        = s_q;
        pins_new   = reg_wdata;
        pins_new[PIN_DO] = 1'b1;
        mem_we_one = 1'b0;
        mem_we_all = 1'b0;
        mem_waddr  = s_q.addr;
        mem_wdata  = shifted;

        if (reg_we) begin
            if (cs_rise) begin
                s_d.st = SER_IDLE;
            end
            if (clk_rise) begin
                unique case (s_d.st)
                    SER_IDLE: begin
                        if (reg_wdata[PIN_DI]) begin
                            s_d.st  = SER_CMD;
                            s_d.cnt = '0;
                            s_d.sr  = '0;
                        end
                    end
                    SER_CMD: begin
                        s_d.sr  = shifted;
                        s_d.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(CMD_BITS)) begin
                            s_d.addr = shifted[ADDR_W-1:0];
                            s_d.cnt  = '0;
                            s_d.st   = SER_IDLE;
                            unique case (opc)
                                OPC_WRITE: s_d.st = SER_DATA_ONE;
                                OPC_READ: begin
                                    s_d.sr   = mem_rdata;
                                    s_d.cnt  = CNT_W'(DATA_W);
                                    s_d.st   = SER_SHOUT;
                                    pins_new[PIN_DO] = 1'b0;
                                end
                                OPC_ERASE: begin
                                    mem_we_one = s_q.wen;
                                    mem_waddr  = shifted[ADDR_W-1:0];
                                    mem_wdata  = '1;
                                end
                                default: begin
                                    unique case (sub)
                                        SUB_UNLOCK: s_d.wen = 1'b1;
                                        SUB_LOCK:   s_d.wen = 1'b0;
                                        SUB_FILL:   s_d.st  = SER_DATA_ALL;
                                        default: begin
                                            mem_we_all = s_q.wen;
                                            mem_wdata  = '1;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    SER_SHOUT: begin
                        pins_new[PIN_DO] = s_q.sr[DATA_W-1];
                        s_d.sr  = {s_q.sr[DATA_W-2:0], 1'b0};
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.st = SER_IDLE;
                        end
                    end
                    default: begin
                        s_d.sr  = shifted;
                        s_d.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(DATA_W)) begin
                            mem_we_one = s_q.wen && (s_q.st == SER_DATA_ONE);
                            mem_we_all = s_q.wen && (s_q.st == SER_DATA_ALL);
                            s_d.st     = SER_IDLE;
                        end
                    end
                endcase
            end else if (reg_wdata[PIN_CS] && clk_fall) begin
                pins_new[PIN_DO] = s_q.pins[PIN_DO];
            end
            s_d.pins = pins_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= SER_IDLE;
            s_q.sr   <= '0;
            s_q.cnt  <= '0;
            s_q.addr <= '0;
            s_q.wen  <= 1'b0;
            s_q.pins <= 8'h01;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_q = s_q.pins;

endmodule

// File: rtl/serial_eeprom_port.sv
module serial_eeprom_port #(
    parameter int         WORDS      = 128,
    parameter int         DATA_W     = 16,
    parameter logic [2:0] SER_REGION = 3'd5,
    parameter logic [7:0] SER_OFFSET = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_region,
    input  logic [7:0] wr_offset,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_offset,
    output logic [7:0] rd_data,
    output logic       gate_open
);

    localparam int ADDR_W = $clog2(WORDS);

    logic              reg_we;
    logic [7:0]        ser_reg;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we_one;
    logic              mem_we_all;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    serial_eeprom_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_region (wr_region),
        .wr_data   (wr_data),
        .open_o    (gate_open)
    );

    assign reg_we = wr_en && gate_open && (wr_region == SER_REGION) && (wr_offset == SER_OFFSET);

    serial_eeprom_fsm #(.WORDS(WORDS), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_wdata  (wr_data),
        .reg_q      (ser_reg),
        .mem_raddr  (mem_raddr),
        .mem_rdata  (mem_rdata),
        .mem_we_one (mem_we_one),
        .mem_we_all (mem_we_all),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    serial_eeprom_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata),
        .we_one (mem_we_one),
        .we_all (mem_we_all),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata)
    );

    assign rd_data = (gate_open && rd_offset == SER_OFFSET) ? ser_reg : 8'hFF;

endmodule

// File: rtl/serial_eeprom_port_chk.sv
module serial_eeprom_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_region,
    input logic [7:0] wr_offset,
    input logic [7:0] wr_data,
    input logic [7:0] rd_offset,
    input logic [7:0] rd_data,
    input logic       gate_open,
    input logic [7:0] ser_reg
);

    logic reg_hit;
    assign reg_hit = wr_en && gate_open && wr_region == 3'd5 && wr_offset == 8'h80;

    AST_WRONG_KEY_A_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region == 3'd0 && wr_data != 8'h0A) |=> !gate_open); // R1

    AST_WRONG_KEY_B_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region == 3'd2 && wr_data != 8'h40) |=> !gate_open); // R2

    AST_CLOSED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && rd_offset == 8'h80) |-> rd_data == 8'hFF); // R3

    AST_CLOSED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && wr_en && wr_region == 3'd5) |=> $stable(ser_reg)); // R3

    AST_OTHER_OFFSET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_offset != 8'h80) |-> rd_data == 8'hFF); // R4

    AST_DO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && !wr_data[7]) |=> ser_reg[0]); // R12

    AST_FALL_HOLDS_DO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && wr_data[7] && !wr_data[6] && ser_reg[6]) |=> ser_reg[0] == $past(ser_reg[0])); // R12

endmodule

bind serial_eeprom_port serial_eeprom_port_chk u_chk (.*);

// File: tb/tb_serial_eeprom_port.sv
module tb_serial_eeprom_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_region = 3'd0;
    logic [7:0] wr_offset = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_offset = 8'h80;
    logic [7:0] rd_data;
    logic       gate_open;

    int total = 0;
    int bad = 0;

    serial_eeprom_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_region (wr_region),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .rd_offset (rd_offset),
        .rd_data   (rd_data),
        .gate_open (gate_open)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] region, input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_region = region;
        wr_offset = off;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [7:0] v);
        rd_offset = off;
        #1;
        v = rd_data;
        rd_offset = 8'h80;
    endtask

    task automatic pin(input logic cs, input logic sck, input logic di);
        bus_wr(3'd5, 8'h80, {cs, sck, 4'b0000, di, 1'b0});
    endtask

    task automatic sbit(input logic di);
        pin(1'b1, 1'b0, di);
        pin(1'b1, 1'b1, di);
    endtask

    task automatic open_gate;
        bus_wr(3'd0, 8'h00, 8'h0A);
        bus_wr(3'd2, 8'h00, 8'h40);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] low);
        pin(1'b0, 1'b0, 1'b0);
        pin(1'b1, 1'b0, 1'b0);
        sbit(1'b1);
        sbit(op[1]);
        sbit(op[0]);
        for (int i = 7; i >= 0; i--) sbit(low[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) sbit(w[i]);
        pin(1'b0, 1'b0, 1'b0);
    endtask

    task automatic write_word(input logic [6:0] a, input logic [15:0] w);
        send_cmd(2'b01, {1'b0, a});
        send_word(w);
    endtask

    task automatic ext_cmd(input logic [1:0] sub);
        send_cmd(2'b00, {sub, 6'b000000});
        pin(1'b0, 1'b0, 1'b0);
    endtask

    // Reads one word; checks dummy bit and falling-edge hold along the way
    task automatic read_word(input logic [6:0] a, output logic [15:0] w);
        logic [7:0] v;
        logic prev;
        send_cmd(2'b10, {1'b0, a});
        rd(8'h80, v);
        chk("R8 dummy zero bit", {31'd0, v[0]}, 32'd0);
        prev = v[0];
        for (int i = 15; i >= 0; i--) begin
            pin(1'b1, 1'b0, 1'b0);
            rd(8'h80, v);
            chk("R12 falling clock holds data-out", {31'd0, v[0]}, {31'd0, prev});
            pin(1'b1, 1'b1, 1'b0);
            rd(8'h80, v);
            w[i] = v[0];
            prev = v[0];
        end
        pin(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R13 gate closed after reset", {31'd0, gate_open}, 32'd0);
        rd(8'h80, v);
        chk("R3 closed read", {24'd0, v}, 32'hFF);
        open_gate();
        chk("R13 gate opens", {31'd0, gate_open}, 32'd1);
        rd(8'h80, v);
        chk("R13 register reset value", {24'd0, v}, 32'h01);
    endtask

    task automatic t_gate;
        logic [7:0] v;
        bus_wr(3'd0, 8'h00, 8'h00);
        chk("R1 wrong key A closes", {31'd0, gate_open}, 32'd0);
        bus_wr(3'd2, 8'h00, 8'h40);
        chk("R1 key A bit cleared too", {31'd0, gate_open}, 32'd0);
        bus_wr(3'd0, 8'h00, 8'h0A);
        chk("R1 key A opens with B set", {31'd0, gate_open}, 32'd1);
        bus_wr(3'd2, 8'h00, 8'h41);
        chk("R2 wrong key B closes", {31'd0, gate_open}, 32'd0);
        pin(1'b1, 1'b1, 1'b1);
        bus_wr(3'd2, 8'h00, 8'h40);
        chk("R2 key A kept", {31'd0, gate_open}, 32'd1);
        rd(8'h80, v);
        chk("R3 closed write ignored", {24'd0, v}, 32'h01);
        bus_wr(3'd5, 8'h81, 8'hC2);
        rd(8'h80, v);
        chk("R4 other offset write ignored", {24'd0, v}, 32'h01);
        rd(8'h81, v);
        chk("R4 other offset reads ones", {24'd0, v}, 32'hFF);
    endtask

    task automatic t_locked_ops;
        logic [15:0] w;
        write_word(7'd5, 16'h1234);
        read_word(7'd5, w);
        chk("R7 write blocked while disabled", {16'd0, w}, 32'hFFFF);
        ext_cmd(2'b11);
        write_word(7'd5, 16'h1234);
        read_word(7'd5, w);
        chk("R7 write stored when enabled", {16'd0, w}, 32'h1234);
    endtask

    task automatic t_addressing;
        logic [15:0] w;
        write_word(7'd127, 16'h8001);
        write_word(7'd0, 16'h7FFE);
        read_word(7'd127, w);
        chk("R6 address 127", {16'd0, w}, 32'h8001);
        read_word(7'd0, w);
        chk("R6 address 0", {16'd0, w}, 32'h7FFE);
        read_word(7'd5, w);
        chk("R6 neighbour untouched", {16'd0, w}, 32'h1234);
    endtask

    task automatic t_erase;
        logic [15:0] w;
        send_cmd(2'b11, 8'd5);
        pin(1'b0, 1'b0, 1'b0);
        read_word(7'd5, w);
        chk("R9 erase one word", {16'd0, w}, 32'hFFFF);
        read_word(7'd0, w);
        chk("R9 erase spares others", {16'd0, w}, 32'h7FFE);
    endtask

    task automatic t_pins;
        logic [7:0] v;
        pin(1'b0, 1'b0, 1'b0);
        rd(8'h80, v);
        chk("R12 undriven data-out high", {24'd0, v}, 32'h01);
        pin(1'b1, 1'b0, 1'b1);
        rd(8'h80, v);
        chk("R4 pin layout readback", {24'd0, v}, 32'h83);
        pin(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cs_restart;
        logic [15:0] w;
        pin(1'b0, 1'b0, 1'b0);
        pin(1'b1, 1'b0, 1'b0);
        sbit(1'b1);
        sbit(1'b0);
        sbit(1'b1);
        sbit(1'b1);
        read_word(7'd127, w);
        chk("R5 chip select restarts", {16'd0, w}, 32'h8001);
    endtask

    task automatic t_fill_wipe;
        logic [15:0] w;
        send_cmd(2'b00, {2'b01, 6'b0});
        send_word(16'hA5C3);
        read_word(7'd0, w);
        chk("R10 write-all word 0", {16'd0, w}, 32'hA5C3);
        read_word(7'd127, w);
        chk("R10 write-all word 127", {16'd0, w}, 32'hA5C3);
        ext_cmd(2'b10);
        read_word(7'd64, w);
        chk("R9 erase-all word 64", {16'd0, w}, 32'hFFFF);
    endtask

    task automatic t_disable;
        logic [15:0] w;
        write_word(7'd3, 16'h0F0F);
        ext_cmd(2'b00);
        write_word(7'd3, 16'h1111);
        read_word(7'd3, w);
        chk("R11 disable blocks write", {16'd0, w}, 32'h0F0F);
        send_cmd(2'b11, 8'd3);
        pin(1'b0, 1'b0, 1'b0);
        ext_cmd(2'b10);
        read_word(7'd3, w);
        chk("R9 erases blocked when disabled", {16'd0, w}, 32'h0F0F);
        ext_cmd(2'b11);
        send_cmd(2'b11, 8'd3);
        pin(1'b0, 1'b0, 1'b0);
        read_word(7'd3, w);
        chk("R11 enable restores erase", {16'd0, w}, 32'hFFFF);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_locked_ops();
        t_addressing();
        t_erase();
        t_pins();
        t_cs_restart();
        t_fill_wipe();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule